// File: doc/BRIEF.md
# Seeded Quad-Port Transmit Scrambler

This block holds four independent 100BASE-TX transmit paths. Each path takes a 5-bit NRZ symbol from a repeater controller and sends it out one bit per clock. Each bit is mixed with the output of an 11-bit maximal-length pseudo-random generator, whose period is 2047 bits. The result is encoded as a three-level MLT3 line state.

Each port's generator starts from a seed built from a 3-bit board address and its own port number. Several devices in one hub therefore never share a scrambler starting point.

The block runs only while the `lock` input reports that the transmit clock synthesizer is locked. While `lock` is low, every line stays at level zero and the symbol phase stays reset. The controller watches `sym_take` to learn in which cycle a new symbol is consumed.

Top module: `quad_tx_scrambler`

## Requirements
- R1: While `rst_n` is low, every port's line code is 2'b00 and each port's generator is loaded with its seed.
- R2: While `lock` is low, every line code is 2'b00 (no transitions) and `sym_take` is low; the generator state is held, not advanced.
- R3: While `lock` is high, `sym_take` is high in the first locked cycle and then in every fifth cycle; the symbol input is sampled only in cycles where `sym_take` is high.
- R4: One symbol bit is transmitted per locked cycle, least significant bit first. The transmitted bit is the symbol bit XOR generator bit 10. In the same cycle the generator shifts left by one and feeds bit 10 XOR bit 8 into bit 0, which implements x^11 + x^9 + 1.
- R5: Port p's seed is {addr[2:0], p[1:0], 6'b100101}, taken from `addr` during reset; it is never zero.
- R6: Port p's line code sits at bits [2p+1:2p]. The codes are 2'b00 for 0, 2'b01 for +1 and 2'b11 for -1; 2'b10 never appears. Each transmitted 1 advances the level one step through the cycle 0, +1, 0, -1, and a 0 holds the level. The new level is visible after the clock edge that consumes the bit.
- R7: When `lock` falls, the next line code is 0 on every port and the symbol phase restarts at zero; when `lock` rises again, `sym_take` is high in that first cycle.
- R8: Over long runs the generator repeats with a period of 2047 locked cycles.
- R9: With all-zero symbols the four ports transmit mutually different line sequences.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock | input | 1 | Synthesizer locked; enables transmission |
| addr | input | 3 | Board address used in the seeds |
| sym | input | PORTS*SYM_W | Symbols, port p at bits [5p+4:5p] |
| sym_take | output | 1 | High in the cycle a symbol is consumed |
| line_lvl | output | 2*PORTS | MLT3 line codes, port p at [2p+1:2p] |

## Verification
The bench changes the symbol inputs on every cycle, including cycles in which `sym_take` is low. A design that sampled symbols outside `sym_take` would then send the wrong bits. The bench drops `lock` in the middle of a symbol. A design that kept its phase or advanced its generator while unlocked would misalign every later bit, and one that held the line level would show a nonzero line while idle. Two resets with different addresses, together with runs of all-zero symbols longer than one generator period, expose three faults: a wrong seed layout, wrong feedback taps, and ports that share a seed.

// File: rtl/quad_tx_scrambler.sv
module quad_tx_scrambler #(
  parameter int PORTS = 4,
  parameter int SYM_W = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     lock,
  input  logic [2:0]               addr,
  input  logic [PORTS*SYM_W-1:0]   sym,
  output logic                     sym_take,
  output logic [2*PORTS-1:0]       line_lvl
);
  localparam int GEN_W = 11;
  localparam int PH_W  = $clog2(SYM_W);

  logic [PH_W-1:0] ph;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                          ph <= '0;
    else if (!lock)                      ph <= '0;
    else if (ph == PH_W'(SYM_W - 1))     ph <= '0;
    else                                 ph <= ph + 1'b1;

  assign sym_take = lock && (ph == '0);

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    logic [SYM_W-1:0] hold, cur;
    logic [GEN_W-1:0] gen;
    logic [1:0]       step;
    logic             tx_bit;
    wire  [GEN_W-1:0] seed = {addr, 2'(p), 6'b100101};

    assign cur    = sym_take ? sym[p*SYM_W +: SYM_W] : hold;
    assign tx_bit = cur[ph] ^ gen[GEN_W-1];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        hold <= '0;
        gen  <= seed;
        step <= 2'd0;
      end else if (!lock) begin
        step <= 2'd0;
      end else begin
        if (sym_take) hold <= sym[p*SYM_W +: SYM_W];
        gen  <= {gen[GEN_W-2:0], gen[10] ^ gen[8]};
        step <= step + {1'b0, tx_bit};
      end

    assign line_lvl[2*p +: 2] = (step == 2'd1) ? 2'b01 :
                                (step == 2'd3) ? 2'b11 : 2'b00;
  end
endmodule

// File: rtl/quad_tx_scrambler_chk.sv
module quad_tx_scrambler_chk #(
  parameter int PORTS = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lock,
  input logic               sym_take,
  input logic [2*PORTS-1:0] line_lvl
);
  // R2, R7
  a_r2_idle_line: assert property (@(posedge clk) disable iff (!rst_n)
    !lock |=> (line_lvl == '0));

  // R3
  a_r3_take_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    sym_take |=> !sym_take);

  // R7
  a_r7_first_take: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> sym_take);

  for (genvar p = 0; p < PORTS; p++) begin : g_chk
    // R6
    a_r6_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
      line_lvl[2*p +: 2] != 2'b10);
    // R6
    a_r6_via_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (line_lvl[2*p +: 2] != 2'b00) |=>
        (line_lvl[2*p +: 2] == $past(line_lvl[2*p +: 2])) || (line_lvl[2*p +: 2] == 2'b00));
  end
endmodule

bind quad_tx_scrambler quad_tx_scrambler_chk #(.PORTS(PORTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .lock(lock), .sym_take(sym_take), .line_lvl(line_lvl));

// File: tb/quad_tx_scrambler_bench.sv
`timescale 1ns/1ps
module quad_tx_scrambler_bench;
  localparam int PORTS = 4;
  localparam int SYM_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lock = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [PORTS*SYM_W-1:0] sym = '0;
  logic sym_take;
  logic [2*PORTS-1:0] line_lvl;

  always #2.5 clk = ~clk;

  quad_tx_scrambler #(.PORTS(PORTS), .SYM_W(SYM_W)) u_quad_tx_scrambler (
    .clk(clk), .rst_n(rst_n), .lock(lock), .addr(addr), .sym(sym),
    .sym_take(sym_take), .line_lvl(line_lvl));

  int vecs = 0, errs = 0;
  string tag = "R1";

  int m_gen [PORTS];
  int m_step[PORTS];
  int m_hold[PORTS];
  int m_ph = 0;
  int seq_sig[PORTS];
  int rng = 32'h1234_5678;

  function automatic int seed_of(int a, int p);
    return (a << 8) | (p << 6) | 6'b100101;
  endfunction

  function automatic int next_rnd();
    rng = rng * 1103515245 + 12345;
    return (rng >>> 8);
  endfunction

  function automatic logic [1:0] code_of(int st);
    case (st % 4)
      1: return 2'b01;
      3: return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0;
      for (int p = 0; p < PORTS; p++) begin
        m_gen[p] = seed_of(addr, p); m_step[p] = 0; m_hold[p] = 0;
      end
    end else if (!lock) begin
      m_ph = 0;
      for (int p = 0; p < PORTS; p++) m_step[p] = 0;
    end else begin
      for (int p = 0; p < PORTS; p++) begin
        int s, b, g;
        if (m_ph == 0) m_hold[p] = int'(sym[p*SYM_W +: SYM_W]);
        s = m_hold[p];
        g = m_gen[p];
        b = ((s >> m_ph) & 1) ^ ((g >> 10) & 1);
        m_gen[p] = ((g << 1) | (((g >> 10) ^ (g >> 8)) & 1)) & 32'h7FF;
        m_step[p] = (m_step[p] + b) % 4;
      end
      m_ph = (m_ph + 1) % SYM_W;
    end
  end

  task automatic check(string what, int act, int exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // mode 0: random symbols, 1: all zeros, 2: all ones
  task automatic cycle(logic lk, int mode);
    @(negedge clk);
    lock = lk;
    case (mode)
      0: sym = PORTS*SYM_W'(next_rnd());
      1: sym = '0;
      default: sym = '1;
    endcase
    #1;
    check("sym_take", sym_take, (lk && m_ph == 0) ? 1 : 0);
    for (int p = 0; p < PORTS; p++) begin
      check($sformatf("line port %0d", p), line_lvl[2*p +: 2], code_of(lk ? m_step[p] : m_step[p]));
      seq_sig[p] = seq_sig[p] * 7 + int'(line_lvl[2*p +: 2]);
    end
  endtask

  task automatic do_reset(logic [2:0] a);
    rst_n = 1'b0; lock = 1'b0; addr = a;
    repeat (3) @(negedge clk);
    tag = "R1";
    check("line in reset", line_lvl, 0);
    check("take in reset", sym_take, 0);
    rst_n = 1'b1;
  endtask

  initial begin
    #(5.0 * 200000);
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    do_reset(3'd5);
    tag = "R2";
    repeat (20) cycle(1'b0, 0);
    tag = "R5_R9";
    for (int p = 0; p < PORTS; p++) seq_sig[p] = 0;
    repeat (60) cycle(1'b1, 1);
    for (int p = 0; p < PORTS; p++)
      for (int q = p + 1; q < PORTS; q++)
        check($sformatf("R9 ports %0d/%0d differ", p, q), (seq_sig[p] != seq_sig[q]) ? 1 : 0, 1);
    tag = "R3_R4_R6";
    repeat (400) cycle(1'b1, 0);
    tag = "R6_ones";
    repeat (40) cycle(1'b1, 2);
    tag = "R7";
    repeat (3) cycle(1'b1, 0);
    repeat (4) cycle(1'b0, 0);
    repeat (7) cycle(1'b1, 0);
    cycle(1'b0, 0);
    repeat (12) cycle(1'b1, 0);
    tag = "R8";
    repeat (4200) cycle(1'b1, 1);
    do_reset(3'd2);
    tag = "R5_addr2";
    repeat (300) cycle(1'b1, 0);
    tag = "R2_end";
    repeat (10) cycle(1'b0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule